// File: doc/BRIEF.md
# Token-Ring Depth Expansion for Chained FIFO Stages

This block builds one deep first-in first-out buffer out of several small stages arranged in a ring. Each stage has its own storage, write pointer, read pointer and word count. Two ownership tokens travel around the ring, one for writing and one for reading. Only the stage that holds the write token takes the shared write enable. Only the stage that holds the read token takes the shared read enable. A stage passes a token to the next stage in the ring when an access reaches its last physical location. The ring therefore fills and drains stage by stage, and the words leave in the order they arrived.

A per-stage strap input, active low, picks the stage that holds both tokens when reset ends. Each stage raises a one-cycle expansion-out pulse, one for writes and one for reads. The next stage in the ring samples that pulse on the following edge and takes the token. Every stage produces active-low empty, full, almost-empty and almost-full indications. These are merged into composite flags. There is no half-full indication, because in a chain that signal would be taken up by the expansion output.

Top module: `fifo_ring`

## Requirements
- R1: While reset is held and directly after it ends, the stage whose `first_n` bit is 0 holds both tokens and no other stage holds either. Every stage is empty, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, `q`=0, and all expansion-out pulses are 0.
- R2: A write is taken only by the stage that holds the write token, and only when that stage holds fewer than SDEPTH words. Every other stage ignores `wr_en`. At most one bit of `wtok` is set at any time.
- R3: A write into a stage's last location (local index SDEPTH-1) clears that stage's `wtok` bit and sets its `wx_out` bit for exactly one cycle. On the next edge, stage (i+1) mod NSTAGE sets its `wtok` bit. During that one-cycle gap, no stage holds the write token and a write presented then is dropped.
- R4: A read from a stage's last location clears that stage's `rtok` bit and sets its `rx_out` bit for one cycle. Stage (i+1) mod NSTAGE takes `rtok` on the next edge. A read presented during that gap is dropped.
- R5: A read is taken only by the read-token holder, and only when that stage holds at least one word. A read of an empty stage leaves `q` and all tokens unchanged.
- R6: `q` shows the word fetched by the most recent read, from the stage that performed it, one edge after the read. `q` is 0 while `oe`=0 or before any read since reset.
- R7: `empty_n` is 0 only when every stage is empty. `full_n` is 0 only when every stage holds SDEPTH words.
- R8: A stage is almost empty when its count is at most AE_OFF, and almost full when its count is at least SDEPTH-AF_OFF. `aempty_n` is 0 only when all stages are almost empty, and `afull_n` is 0 only when all stages are almost full.
- R9: Words leave the ring in the order they were accepted, across stage boundaries and ring wrap-around.
- R10: When the write token returns to a stage that is still full, the write token stays there and further writes are ignored until a read frees a location in that stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_n | input | NSTAGE | Strap per stage; a 0 marks the stage that starts with both tokens |
| wr_en | input | 1 | Shared write enable |
| din | input | W | Write data |
| rd_en | input | 1 | Shared read enable |
| oe | input | 1 | Output enable for `q` |
| q | output | W | Read data from the stage that last performed a read |
| empty_n | output | 1 | Composite empty, active low |
| full_n | output | 1 | Composite full, active low |
| aempty_n | output | 1 | Composite almost empty, active low |
| afull_n | output | 1 | Composite almost full, active low |
| wtok | output | NSTAGE | Write-token ownership per stage |
| rtok | output | NSTAGE | Read-token ownership per stage |
| wx_out | output | NSTAGE | Write expansion-out pulse per stage |
| rx_out | output | NSTAGE | Read expansion-out pulse per stage |

## Verification
The bench builds the ring with its defaults: three stages of four words, eight-bit data, and both almost offsets set to 1. With four-word stages, a token handoff happens on every fourth accepted access. Twelve writes fill the whole ring. A full lap of both tokens, with the write token returning to a stage that is still full, therefore fits into short bursts. A pseudo-random phase mixes reads and writes around the handoff gaps. A second reset with a different strap starts the ring from another stage.

// File: rtl/fifo_ring.sv
module fifo_ring #(
  parameter int NSTAGE = 3,
  parameter int SDEPTH = 4,
  parameter int W      = 8,
  parameter int AE_OFF = 1,
  parameter int AF_OFF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAGE-1:0] first_n,
  input  logic              wr_en,
  input  logic [W-1:0]      din,
  input  logic              rd_en,
  input  logic              oe,
  output logic [W-1:0]      q,
  output logic              empty_n,
  output logic              full_n,
  output logic              aempty_n,
  output logic              afull_n,
  output logic [NSTAGE-1:0] wtok,
  output logic [NSTAGE-1:0] rtok,
  output logic [NSTAGE-1:0] wx_out,
  output logic [NSTAGE-1:0] rx_out
);

  localparam int PW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1;
  localparam int CW = $clog2(SDEPTH + 1);

  logic [NSTAGE-1:0] wgo, rgo, drv;
  logic [NSTAGE-1:0] st_empty_n, st_full_n, st_ae_n, st_af_n;
  logic [W-1:0]      oreg [NSTAGE];

  for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stage
    localparam int NX = (gi + 1) % NSTAGE;
    localparam int PV = (gi + NSTAGE - 1) % NSTAGE;

    logic [W-1:0]  mem [SDEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [W-1:0]  orq;
    logic          wt, rt, wxo, rxo, dv;
    logic          wlast, rlast;

    assign wlast = (wp == PW'(SDEPTH - 1));
    assign rlast = (rp == PW'(SDEPTH - 1));
    assign wgo[gi] = wr_en & wt & (cnt != CW'(SDEPTH));
    assign rgo[gi] = rd_en & rt & (cnt != '0);

    always_ff @(posedge clk) begin
      if (wgo[gi]) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wt  <= ~first_n[gi];
        rt  <= ~first_n[gi];
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        wxo <= 1'b0;
        rxo <= 1'b0;
        orq <= '0;
        dv  <= 1'b0;
      end else begin
        wxo <= wgo[gi] & wlast;
        rxo <= rgo[gi] & rlast;
        cnt <= cnt + CW'(wgo[gi]) - CW'(rgo[gi]);

        if (wgo[gi]) begin
          wp <= wlast ? '0 : wp + PW'(1);
          if (wlast) wt <= 1'b0;
        end else if (wx_out[PV]) begin
          wt <= 1'b1;
        end

        if (rgo[gi]) begin
          rp  <= rlast ? '0 : rp + PW'(1);
          orq <= mem[rp];
          if (rlast) rt <= 1'b0;
        end else if (rx_out[PV]) begin
          rt <= 1'b1;
        end

        if (rgo[gi])  dv <= 1'b1;
        else if (|rgo) dv <= 1'b0;
      end
    end

    assign wtok[gi]       = wt;
    assign rtok[gi]       = rt;
    assign wx_out[gi]     = wxo;
    assign rx_out[gi]     = rxo;
    assign drv[gi]        = dv;
    assign oreg[gi]       = orq;
    assign st_empty_n[gi] = (cnt != '0);
    assign st_full_n[gi]  = (cnt != CW'(SDEPTH));
    assign st_ae_n[gi]    = (cnt > CW'(AE_OFF));
    assign st_af_n[gi]    = (cnt < CW'(SDEPTH - AF_OFF));

    // R3
    wr_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wx_out[gi] |=> wtok[NX]);
    // R3
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wx_out[gi] |=> !wx_out[gi]);
    // R4
    rd_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out[gi] |=> rtok[NX]);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_full_n[gi] && !rgo[gi]) |=> !st_full_n[gi]);
  end

  always_comb begin
    q = '0;
    for (int i = 0; i < NSTAGE; i++)
      if (oe && drv[i]) q = q | oreg[i];
  end

  assign empty_n  = |st_empty_n;
  assign full_n   = |st_full_n;
  assign aempty_n = |st_ae_n;
  assign afull_n  = |st_af_n;

  // R2
  one_wtok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wtok));
  // R4
  one_rtok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rtok));
  // R6
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv));
  // R5
  rd_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && oe) |=> (!oe || $stable(q)));

endmodule

// File: tb/sim_fifo_ring.sv
module sim_fifo_ring;
  localparam int CLK_P = 10;
  localparam int N  = 3;
  localparam int SD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] first_n = 3'b110;
  logic wr_en = 1'b0, rd_en = 1'b0, oe = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] q;
  logic empty_n, full_n, aempty_n, afull_n;
  logic [N-1:0] wtok, rtok, wx_out, rx_out;

  int checks = 0, errors = 0;

  int mcnt [N], mwp [N], mrp [N];
  logic [7:0] mmem [N][SD];
  logic [7:0] mo [N];
  int wown, wpend, rown, rpend, mdrv;
  logic [N-1:0] ewx, erx;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_P/2) clk = ~clk;

  fifo_ring u0 (
    .clk(clk), .rst_n(rst_n), .first_n(first_n), .wr_en(wr_en), .din(din),
    .rd_en(rd_en), .oe(oe), .q(q), .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n), .wtok(wtok), .rtok(rtok),
    .wx_out(wx_out), .rx_out(rx_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int onehot(input int idx);
    return (idx >= 0) ? (1 << idx) : 0;
  endfunction

  task automatic compare_all(input string qreq);
    int eq, ae, af, ee, ef;
    eq = (oe && mdrv >= 0) ? int'(mo[mdrv]) : 0;
    ee = 0; ef = 0; ae = 0; af = 0;
    for (int i = 0; i < N; i++) begin
      if (mcnt[i] != 0) ee = 1;
      if (mcnt[i] != SD) ef = 1;
      if (mcnt[i] > 1) ae = 1;
      if (mcnt[i] < SD - 1) af = 1;
    end
    chk(qreq, "q", int'(q), eq);
    chk("R7", "empty_n", int'(empty_n), ee);
    chk("R7", "full_n", int'(full_n), ef);
    chk("R8", "aempty_n", int'(aempty_n), ae);
    chk("R8", "afull_n", int'(afull_n), af);
    chk("R2", "wtok", int'(wtok), onehot(wown));
    chk("R5", "rtok", int'(rtok), onehot(rown));
    chk("R3", "wx_out", int'(wx_out), int'(ewx));
    chk("R4", "rx_out", int'(rx_out), int'(erx));
  endtask

  task automatic do_reset(input logic [N-1:0] strap, input int owner);
    rst_n = 1'b0; first_n = strap; wr_en = 1'b0; rd_en = 1'b0; oe = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      mcnt[i] = 0; mwp[i] = 0; mrp[i] = 0; mo[i] = '0;
    end
    wown = owner; rown = owner; wpend = -1; rpend = -1; mdrv = -1;
    ewx = '0; erx = '0;
    compare_all("R1");
    rst_n = 1'b1;
    compare_all("R1");
  endtask

  task automatic cyc(input logic we, input logic [7:0] d, input logic re, input logic o,
                     input string qreq);
    int wg, rg;
    wr_en = we; din = d; rd_en = re; oe = o;
    @(posedge clk);
    wg = -1; rg = -1;
    if (we && wown >= 0 && mcnt[wown] < SD) wg = wown;
    if (re && rown >= 0 && mcnt[rown] > 0) rg = rown;
    ewx = '0; erx = '0;
    if (wpend >= 0) begin wown = wpend; wpend = -1; end
    if (rpend >= 0) begin rown = rpend; rpend = -1; end
    if (rg >= 0) begin
      mo[rg] = mmem[rg][mrp[rg]];
      mdrv = rg;
      mcnt[rg]--;
      if (mrp[rg] == SD - 1) begin
        mrp[rg] = 0; erx[rg] = 1'b1; rown = -1; rpend = (rg + 1) % N;
      end else mrp[rg]++;
    end
    if (wg >= 0) begin
      mmem[wg][mwp[wg]] = d;
      mcnt[wg]++;
      if (mwp[wg] == SD - 1) begin
        mwp[wg] = 0; ewx[wg] = 1'b1; wown = -1; wpend = (wg + 1) % N;
      end else mwp[wg]++;
    end
    @(negedge clk);
    compare_all(qreq);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: strap picks stage 0
    do_reset(3'b110, 0);
    // R2 R3: writes across a stage boundary, one dropped in the gap
    for (int k = 0; k < 6; k++) cyc(1'b1, 8'(8'h10 + k), 1'b0, 1'b1, "R6");
    // R4 R6 R9: drain with oe toggling
    for (int k = 0; k < 8; k++) cyc(1'b0, 8'h00, 1'b1, 1'(k % 3 != 1), "R9");
    // R5: reads of an empty ring
    for (int k = 0; k < 3; k++) cyc(1'b0, 8'h00, 1'b1, 1'b1, "R5");
    // R10: fill the whole ring, then keep writing
    for (int k = 0; k < 24; k++) cyc(1'b1, 8'(8'h40 + k), 1'b0, 1'b1, "R6");
    chk("R10", "full_n after fill", int'(full_n), 0);
    chk("R10", "wtok kept on full stage", int'(wtok), onehot(wown));
    // R4 R9: free one slot, then write again
    cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
    cyc(1'b1, 8'hEE, 1'b0, 1'b1, "R10");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0], lf[15:8], lf[3] | lf[5], lf[7] | lf[2], "R9");
    end
    for (int k = 0; k < 16; k++) cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
    // R1: strap picks stage 2
    do_reset(3'b011, 2);
    for (int k = 0; k < 9; k++) cyc(1'b1, 8'(8'hA0 + k), 1'b0, 1'b0, "R6");
    for (int k = 0; k < 12; k++) cyc(1'b0, 8'h00, 1'b1, 1'b1, "R9");
    for (int k = 0; k < 200; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[1] | lf[4], lf[15:8], lf[6], 1'b1, "R9");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule